// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets several processors on one chip hand short messages to each other through a memory-mapped register file. It holds a parameterised number of one-way channels. Each channel has an owner field, a target-line register, a pending-line status, a line mask, a mode/status word and eight 32-bit message words. A sender claims a free channel by writing its one-hot bit to the owner register and reading it back. It then fills the message words, picks the target interrupt lines and unmasks them, and writes its own bit to the send register. The channel then leaves idle and raises the chosen interrupt lines toward the receiving processors.

A global lock protects every channel register. Until the unlock key is written, channel writes have no effect. In automatic-acknowledge mode the channel marks itself acknowledged one cycle after the send, so the sender never waits for the receiver. Writing zero to the owner register hands the channel back to the idle pool.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the lock reads 1, every channel reads idle (mode bit 4 = 1, bit 7 = 0, bit 0 = 0) with owner 0 and all mask bits set to 1, and `irq_out` is 0.
- R2: Writing 0x1ACCE551 to byte address 0xA00 opens the lock, which then reads 0. Writing any other value there closes it, and it then reads 1.
- R3: While the lock is closed, writes to any channel register leave that register unchanged.
- R4: Channel c occupies bytes c*0x40 to c*0x40+0x3F. Register offsets are owner 0x00, target 0x04, target clear 0x08, pending status 0x0C (read only), mode 0x10, mask 0x14, mask-side clear 0x18, send 0x1C and message word i at 0x20+4*i (i = 0..7). Message words read back what was written.
- R5: A nonzero write to the owner register is stored only when the owner is 0. A nonzero write to an owned channel is dropped. Writing 0 releases the channel: the owner becomes 0, mode bit 4 returns to 1 and mode bit 7 to 0.
- R6: A send write whose data shares a set bit with the owner, on an owned idle channel, clears mode bit 4 and ORs the target register into the pending status, visible on the next read.
- R7: `irq_out[j]` is 1 exactly when some channel has pending bit j set and mask bit j clear. A mask bit of 1 blocks that line.
- R8: Mode bit 0 selects automatic acknowledge. After a send with bit 0 = 1, mode bit 7 reads 0 in the cycle right after the send edge and 1 from the following edge. With bit 0 = 0 it stays 0.
- R9: Writing 1s to the target clear (0x08) or mask-side clear (0x18) register clears the matching pending bits.
- R10: A send write is ignored when the channel has no owner or when its data shares no bit with the owner. The channel stays idle and nothing becomes pending.
- R11: Addresses of channels at or above the channel count accept no writes and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | N_LINE | Remote interrupt lines, OR of all channels |

## Verification
The bench builds the block with 4 channels and 8 interrupt lines. With only 4 channels, the window of channel 5 is reachable, so out-of-range writes and reads can be shown to do nothing. With 8 lines, the interrupt lines are narrower than the data bus, so mask and target values wider than the line count must truncate. The small line count also makes it possible to mix masked and unmasked targets on one channel and watch both the pending status and `irq_out` through the full send, clear and release sequence in both acknowledge modes.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int N_CHAN = 32,
  parameter int N_LINE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_LINE-1:0] irq_out
);

  localparam logic [11:0] LOCK_ADDR  = 12'hA00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;
  localparam logic [5:0]  CH_LIMIT   = 6'(N_CHAN);
  localparam int          WORDS      = 8;

  logic lock_q;
  logic [N_LINE-1:0] src_q  [N_CHAN];
  logic [N_LINE-1:0] dst_q  [N_CHAN];
  logic [N_LINE-1:0] pend_q [N_CHAN];
  logic [N_LINE-1:0] mask_q [N_CHAN];
  logic [31:0]       data_q [N_CHAN][WORDS];
  logic [N_CHAN-1:0] auto_q, idle_q, ack_q, arm_q;

  wire [4:0] ch_idx     = bus_addr[10:6];
  wire [3:0] reg_sel    = bus_addr[5:2];
  wire       chan_space = ~bus_addr[11] && ({1'b0, ch_idx} < CH_LIMIT);
  wire       lock_hit   = bus_addr[11:2] == LOCK_ADDR[11:2];
  wire       ch_we      = bus_wr && chan_space && !lock_q;
  wire [N_LINE-1:0] wbits = bus_wdata[N_LINE-1:0];

  logic unused_addr_lsb;
  assign unused_addr_lsb = ^bus_addr[1:0];

  logic [N_CHAN-1:0] sel, send_go;
  always_comb begin
    for (int c = 0; c < N_CHAN; c++) begin
      sel[c]     = ch_we && (ch_idx == 5'(c));
      send_go[c] = sel[c] && (reg_sel == 4'd7) && idle_q[c] &&
                   (|src_q[c]) && (|(wbits & src_q[c]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      auto_q <= '0;
      idle_q <= '1;
      ack_q  <= '0;
      arm_q  <= '0;
      for (int c = 0; c < N_CHAN; c++) begin
        src_q[c]  <= '0;
        dst_q[c]  <= '0;
        pend_q[c] <= '0;
        mask_q[c] <= '1;
        for (int w = 0; w < WORDS; w++) data_q[c][w] <= '0;
      end
    end else begin
      if (bus_wr && lock_hit) lock_q <= (bus_wdata != UNLOCK_KEY);
      for (int c = 0; c < N_CHAN; c++) begin
        ack_q[c] <= ack_q[c] | arm_q[c];
        arm_q[c] <= 1'b0;
        if (sel[c]) begin
          unique case (reg_sel)
            4'd0: begin
              if (wbits == '0) begin
                src_q[c]  <= '0;
                idle_q[c] <= 1'b1;
                ack_q[c]  <= 1'b0;
                arm_q[c]  <= 1'b0;
              end else if (src_q[c] == '0) begin
                src_q[c] <= wbits;
              end
            end
            4'd1: dst_q[c]  <= wbits;
            4'd2: pend_q[c] <= pend_q[c] & ~wbits;
            4'd4: auto_q[c] <= bus_wdata[0];
            4'd5: mask_q[c] <= wbits;
            4'd6: pend_q[c] <= pend_q[c] & ~wbits;
            4'd7: begin
              if (send_go[c]) begin
                idle_q[c] <= 1'b0;
                pend_q[c] <= pend_q[c] | dst_q[c];
                arm_q[c]  <= auto_q[c];
              end
            end
            default: begin
              if (reg_sel[3]) data_q[c][reg_sel[2:0]] <= bus_wdata;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (lock_hit) begin
      bus_rdata = {31'b0, lock_q};
    end else if (chan_space) begin
      for (int c = 0; c < N_CHAN; c++) begin
        if (ch_idx == 5'(c)) begin
          unique case (reg_sel)
            4'd0: bus_rdata = 32'(src_q[c]);
            4'd1: bus_rdata = 32'(dst_q[c]);
            4'd3: bus_rdata = 32'(pend_q[c]);
            4'd4: bus_rdata = {24'b0, ack_q[c], 2'b0, idle_q[c], 3'b0, auto_q[c]};
            4'd5: bus_rdata = 32'(mask_q[c]);
            default: if (reg_sel[3]) bus_rdata = data_q[c][reg_sel[2:0]];
          endcase
        end
      end
    end
  end

  logic [N_LINE-1:0] irq_acc;
  always_comb begin
    irq_acc = '0;
    for (int c = 0; c < N_CHAN; c++) irq_acc = irq_acc | (pend_q[c] & ~mask_q[c]);
  end
  assign irq_out = irq_acc;

  assert_lock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lock_hit) |=> (lock_q == ($past(bus_wdata) != UNLOCK_KEY)));

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chk
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && bus_wr && chan_space && ch_idx == 5'(g)) |=>
        ($stable(src_q[g]) && $stable(dst_q[g]) && $stable(mask_q[g])));
    assert_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q[g] |-> !idle_q[g]);
    assert_pend_by_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q[g] & ~$past(pend_q[g]))) |-> $past(send_go[g]));
    assert_auto_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (send_go[g] && auto_q[g]) |=> ##1 (ack_q[g] || idle_q[g]));
  end

endmodule

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
  localparam int NC = 4;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] irq_out;

  int tests = 0;
  int fails = 0;

  ipc_mailbox #(.N_CHAN(NC), .N_LINE(NL)) u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #10 clk = ~clk;

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input [11:0] a, input [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input [11:0] a, input [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input [NL-1:0] exp);
    #1;
    chk(req, 32'(irq_out), 32'(exp));
  endtask

  task automatic t_reset;
    rd_chk("R1 lock", 12'hA00, 32'h1);
    rd_chk("R1 mode", 12'h010, 32'h10);
    rd_chk("R1 owner", 12'h0C0, 32'h0);
    rd_chk("R1 mask", 12'h054, 32'hFF);
    irq_chk("R1 irq", '0);
  endtask

  task automatic t_locked_ignore;
    wr(12'h000, 32'h1);
    rd_chk("R3 owner locked", 12'h000, 32'h0);
    wr(12'h020, 32'h1234);
    rd_chk("R3 data locked", 12'h020, 32'h0);
  endtask

  task automatic t_lock;
    wr(12'hA00, 32'h12345678);
    rd_chk("R2 wrong key", 12'hA00, 32'h1);
    wr(12'hA00, 32'h1ACCE551);
    rd_chk("R2 key", 12'hA00, 32'h0);
  endtask

  task automatic t_claim;
    wr(12'h000, 32'h04);
    rd_chk("R5 claim", 12'h000, 32'h04);
    wr(12'h000, 32'h02);
    rd_chk("R5 owned", 12'h000, 32'h04);
    for (int i = 0; i < 8; i++) wr(12'h0A0 + 12'(4*i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd_chk("R4 data", 12'h0A0 + 12'(4*i), 32'hA000_0000 + 32'(i));
  endtask

  task automatic t_send_auto;
    wr(12'h080, 32'h01);
    wr(12'h084, 32'h108);
    wr(12'h094, 32'hF7);
    wr(12'h090, 32'h1);
    irq_chk("R7 before send", '0);
    wr(12'h09C, 32'h01);
    rd_chk("R8 ack not yet", 12'h090, 32'h01);
    irq_chk("R7 unmasked", 8'h08);
    @(negedge clk);
    rd_chk("R8 auto ack", 12'h090, 32'h81);
    rd_chk("R6 pending", 12'h08C, 32'h08);
    wr(12'h088, 32'h08);
    rd_chk("R9 dclr", 12'h08C, 32'h0);
    irq_chk("R9 irq off", '0);
    wr(12'h080, 32'h0);
    rd_chk("R5 release", 12'h090, 32'h11);
    rd_chk("R5 owner zero", 12'h080, 32'h0);
  endtask

  task automatic t_send_manual;
    wr(12'h040, 32'h02);
    wr(12'h044, 32'h30);
    wr(12'h054, 32'hDF);
    wr(12'h05C, 32'h02);
    repeat (3) @(negedge clk);
    rd_chk("R8 manual no ack", 12'h050, 32'h00);
    rd_chk("R6 pending", 12'h04C, 32'h30);
    irq_chk("R7 partial mask", 8'h20);
    wr(12'h058, 32'h10);
    rd_chk("R9 iclr", 12'h04C, 32'h20);
    irq_chk("R7 still", 8'h20);
    wr(12'h058, 32'h20);
    irq_chk("R9 irq off", '0);
    wr(12'h040, 32'h0);
    rd_chk("R5 release", 12'h050, 32'h10);
  endtask

  task automatic t_bad_send;
    wr(12'h0C4, 32'h01);
    wr(12'h0DC, 32'h01);
    rd_chk("R10 no owner", 12'h0D0, 32'h10);
    rd_chk("R10 no pend", 12'h0CC, 32'h0);
    wr(12'h0C0, 32'h01);
    wr(12'h0DC, 32'h02);
    rd_chk("R10 wrong bit", 12'h0D0, 32'h10);
    rd_chk("R10 no pend 2", 12'h0CC, 32'h0);
  endtask

  task automatic t_range;
    wr(12'h160, 32'hDEAD);
    rd_chk("R11 read zero", 12'h160, 32'h0);
    rd_chk("R11 ch0 data", 12'h020, 32'h0);
    wr(12'hA00, 32'h0);
    rd_chk("R2 relock", 12'hA00, 32'h1);
    wr(12'h0A0, 32'h5555);
    rd_chk("R3 relocked data", 12'h0A0, 32'hA000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_ignore();
    t_lock();
    t_claim();
    t_send_auto();
    t_send_manual();
    t_bad_send();
    t_range();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule